// File: doc/BRIEF.md
# General-Purpose I/O Controller with Per-Pin Interrupts

This block is a 32-line general-purpose I/O peripheral on an APB slave port. Each line can be an input or an output, and the two settings are handled separately. Software changes the direction and the output data by writing bit masks that act on the lines. Bits set to 1 act on their line. Bits set to 0 leave their line as it is. Because of this, separate tasks can own separate pins and never need a read-modify-write sequence. Each pad is modelled as three vectors: an output value, an output enable and an input.

Every pad input passes through a two-flop synchronizer before any logic uses it. Software reads the synchronized value back as a state word. Each line can also raise an interrupt. The interrupt can be level sensitive (active high or active low) or edge sensitive (rising, falling or either edge). Each line has its own enable. Edge events are latched until software clears them. Level conditions follow the pin. All enabled pending conditions are ORed onto one interrupt output.

Top module: `gpio_apb_irq`

## Requirements
- R1: After reset, every pad is an input (`pad_oe_o` = 0), `pad_out_o` = 0, all interrupt enables and configuration words are 0, no edge is latched, and `irq_o` = 0.
- R2: Writing mask M to offset 0x00 clears the output-enable bits selected by M, so those pins become inputs. Writing M to 0x04 sets those bits, so those pins become outputs. Bits where M is 0 keep their direction. Reading either offset returns the output-enable word (bit n = 1 means pin n drives).
- R3: Writing M to offset 0x08 sets `pad_out_o` bits where M is 1, and no other bits. Reading 0x08 returns the synchronized pin state word.
- R4: Writing M to offset 0x0C clears `pad_out_o` bits where M is 1, and no other bits. Reading 0x0C returns the pending-interrupt word. The output data changes only through writes to 0x08 and 0x0C.
- R5: A change on `pad_in_i` appears in the state word and in interrupt detection after two clock edges. A read whose access cycle comes one edge after the change still returns the old value.
- R6: A pin whose type bit (offset 0x14) is 0 is level sensitive. With polarity bit (0x18) = 1 it is pending while the pin is high. With polarity bit = 0 it is pending while the pin is low. The pending bit drops as soon as the condition goes away.
- R7: A pin whose type bit is 1 is edge sensitive. If its both-edge bit (0x1C) is 1, either edge latches it. Otherwise polarity 1 selects the rising edge and polarity 0 the falling edge. A latched edge stays pending until 1 is written to that pin's bit at offset 0x20.
- R8: Interrupt enable is the word at 0x10. A disabled pin reads 0 in the pending word, latches no edge and never contributes to `irq_o`.
- R9: `irq_o` is high exactly when the pending word is non-zero.
- R10: If a new selected edge arrives in the same cycle as a clear write for that pin, the pin stays pending.
- R11: The words at 0x10, 0x14, 0x18 and 0x1C read back what was written. Offset 0x20 reads as 0. Transfers complete without wait states (`pready_o` = 1). Pin n maps to bit n of every word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB enable (access phase) |
| pwrite_i | input | 1 | APB write strobe |
| paddr_i | input | 6 | APB byte address |
| pwdata_i | input | 32 | APB write data |
| prdata_o | output | 32 | APB read data |
| pready_o | output | 1 | APB ready, always 1 |
| pad_in_i | input | 32 | Raw pad input values |
| pad_out_o | output | 32 | Pad output values |
| pad_oe_o | output | 32 | Pad output enables |
| irq_o | output | 1 | Combined interrupt |

## Verification
The assertions assume that APB transfers follow the protocol: a setup cycle with `psel_i` high comes before each access cycle, and address and data stay stable across the transfer. The assertions also assume that `pad_in_i` may change on any cycle. The bench keeps to this by issuing every transfer from one task with a fixed setup/access sequence. It changes the pads on falling clock edges, and in random phases it waits four cycles after each pad change, so that edge and level expectations do not depend on synchronizer timing. Directed phases then place a pad change and a clear write on exactly the same cycle, and sample the state word one edge after a change.

// File: rtl/gpio_apb_pkg.sv
package gpio_apb_pkg;
  localparam int unsigned DATA_W = 32;

  // word index = paddr[5:2]
  typedef enum logic [3:0] {
    SEL_MK_IN   = 4'h0,
    SEL_MK_OUT  = 4'h1,
    SEL_SET_ST  = 4'h2,
    SEL_CLR_PND = 4'h3,
    SEL_IEN     = 4'h4,
    SEL_ITYPE   = 4'h5,
    SEL_IPOL    = 4'h6,
    SEL_IBOTH   = 4'h7,
    SEL_ICLR    = 4'h8
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/gpio_pin_irq.sv
module gpio_pin_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  input  logic en_i,
  input  logic edge_mode_i,
  input  logic pol_i,
  input  logic both_i,
  input  logic clr_i,
  output logic pend_o,
  output logic latch_o
);
  logic prev_q, latch_q;
  logic rise, fall, hit, level_act;

  assign rise      = sync_i & ~prev_q;
  assign fall      = ~sync_i & prev_q;
  assign hit       = en_i & edge_mode_i & (both_i ? (rise | fall) : (pol_i ? rise : fall));
  assign level_act = pol_i ? sync_i : ~sync_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      prev_q  <= sync_i;
      // a fresh edge wins over a simultaneous clear
      latch_q <= hit | (latch_q & ~clr_i);
    end
  end

  assign pend_o  = en_i & (edge_mode_i ? latch_q : level_act);
  assign latch_o = latch_q;
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_apb_pkg::*;
#(
  parameter int unsigned N      = 32,
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [N-1:0]      wdata_i,
  input  logic [N-1:0]      state_i,
  input  logic [N-1:0]      pend_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [N-1:0]      oe_o,
  output logic [N-1:0]      out_o,
  output logic [N-1:0]      ien_o,
  output logic [N-1:0]      itype_o,
  output logic [N-1:0]      ipol_o,
  output logic [N-1:0]      iboth_o,
  output logic [N-1:0]      iclr_o
);
  localparam int unsigned SEL_W = ADDR_W - 2;

  logic [SEL_W-1:0] sel;
  logic             wr;
  logic [N-1:0]     oe_q, out_q, ien_q, itype_q, ipol_q, iboth_q;
  logic [N-1:0]     rd_n;
  logic             unused_addr;

  assign sel         = paddr_i[ADDR_W-1:2];
  assign wr          = psel_i & penable_i & pwrite_i;
  assign unused_addr = ^paddr_i[1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_q    <= '0;
      out_q   <= '0;
      ien_q   <= '0;
      itype_q <= '0;
      ipol_q  <= '0;
      iboth_q <= '0;
    end else if (wr) begin
      case (sel)
        SEL_MK_IN:   oe_q    <= oe_q & ~wdata_i;
        SEL_MK_OUT:  oe_q    <= oe_q | wdata_i;
        SEL_SET_ST:  out_q   <= out_q | wdata_i;
        SEL_CLR_PND: out_q   <= out_q & ~wdata_i;
        SEL_IEN:     ien_q   <= wdata_i;
        SEL_ITYPE:   itype_q <= wdata_i;
        SEL_IPOL:    ipol_q  <= wdata_i;
        SEL_IBOTH:   iboth_q <= wdata_i;
        default: ;
      endcase
    end
  end

  assign iclr_o = (wr && sel == SEL_W'(SEL_ICLR)) ? wdata_i : '0;

  always_comb begin
    case (sel)
      SEL_MK_IN, SEL_MK_OUT: rd_n = oe_q;
      SEL_SET_ST:            rd_n = state_i;
      SEL_CLR_PND:           rd_n = pend_i;
      SEL_IEN:               rd_n = ien_q;
      SEL_ITYPE:             rd_n = itype_q;
      SEL_IPOL:              rd_n = ipol_q;
      SEL_IBOTH:             rd_n = iboth_q;
      default:               rd_n = '0;
    endcase
    rdata_o       = '0;
    rdata_o[N-1:0] = psel_i ? rd_n : '0;
  end

  assign oe_o    = oe_q;
  assign out_o   = out_q;
  assign ien_o   = ien_q;
  assign itype_o = itype_q;
  assign ipol_o  = ipol_q;
  assign iboth_o = iboth_q;
endmodule

// File: rtl/gpio_apb_irq.sv
module gpio_apb_irq
  import gpio_apb_pkg::*;
#(
  parameter int unsigned N      = 32,
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [DATA_W-1:0] pwdata_i,
  output logic [DATA_W-1:0] prdata_o,
  output logic              pready_o,
  input  logic [N-1:0]      pad_in_i,
  output logic [N-1:0]      pad_out_o,
  output logic [N-1:0]      pad_oe_o,
  output logic              irq_o
);
  logic [N-1:0] sync_w, pend_w, latch_w;
  logic [N-1:0] ien_w, itype_w, ipol_w, iboth_w, iclr_w;

  gpio_sync2 #(.W(N)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pad_in_i),
    .q_o    (sync_w)
  );

  gpio_regs #(.N(N), .ADDR_W(ADDR_W)) i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .psel_i    (psel_i),
    .penable_i (penable_i),
    .pwrite_i  (pwrite_i),
    .paddr_i   (paddr_i),
    .wdata_i   (pwdata_i[N-1:0]),
    .state_i   (sync_w),
    .pend_i    (pend_w),
    .rdata_o   (prdata_o),
    .oe_o      (pad_oe_o),
    .out_o     (pad_out_o),
    .ien_o     (ien_w),
    .itype_o   (itype_w),
    .ipol_o    (ipol_w),
    .iboth_o   (iboth_w),
    .iclr_o    (iclr_w)
  );

  for (genvar g = 0; g < N; g++) begin : g_pin
    gpio_pin_irq i_pin (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .sync_i      (sync_w[g]),
      .en_i        (ien_w[g]),
      .edge_mode_i (itype_w[g]),
      .pol_i       (ipol_w[g]),
      .both_i      (iboth_w[g]),
      .clr_i       (iclr_w[g]),
      .pend_o      (pend_w[g]),
      .latch_o     (latch_w[g])
    );
  end

  assign irq_o    = |pend_w;
  assign pready_o = 1'b1;
endmodule

// File: rtl/gpio_apb_irq_chk.sv
module gpio_apb_irq_chk #(
  parameter int unsigned N      = 32,
  parameter int unsigned ADDR_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              psel_i,
  input logic              penable_i,
  input logic              pwrite_i,
  input logic [ADDR_W-1:0] paddr_i,
  input logic [31:0]       pwdata_i,
  input logic [N-1:0]      pad_in_i,
  input logic [N-1:0]      pad_out_o,
  input logic [N-1:0]      pad_oe_o,
  input logic              irq_o,
  input logic [N-1:0]      sync_w,
  input logic [N-1:0]      latch_w,
  input logic [N-1:0]      ien_w,
  input logic [N-1:0]      iclr_w
);
  logic       wr;
  logic [3:0] sel;
  logic [1:0] cyc_q;

  assign wr  = psel_i & penable_i & pwrite_i;
  assign sel = 4'(paddr_i[ADDR_W-1:2]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cyc_q <= '0;
    else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
  end

  assert_make_input_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && sel == 4'h0) |=> pad_oe_o == ($past(pad_oe_o) & ~$past(pwdata_i[N-1:0])));

  assert_make_output_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && sel == 4'h1) |=> pad_oe_o == ($past(pad_oe_o) | $past(pwdata_i[N-1:0])));

  assert_set_out_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && sel == 4'h2) |=> pad_out_o == ($past(pad_out_o) | $past(pwdata_i[N-1:0])));

  assert_clr_out_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && sel == 4'h3) |=> pad_out_o == ($past(pad_out_o) & ~$past(pwdata_i[N-1:0])));

  assert_out_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr && (sel == 4'h2 || sel == 4'h3)) |=> $stable(pad_out_o));

  assert_sync_delay_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 2'd2) |-> sync_w == $past(pad_in_i, 2));

  assert_latch_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(latch_w) & ~latch_w) & ~$past(iclr_w)) == '0);

  assert_irq_needs_en_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (ien_w != '0));
endmodule

bind gpio_apb_irq gpio_apb_irq_chk #(.N(N), .ADDR_W(ADDR_W)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .psel_i    (psel_i),
  .penable_i (penable_i),
  .pwrite_i  (pwrite_i),
  .paddr_i   (paddr_i),
  .pwdata_i  (pwdata_i),
  .pad_in_i  (pad_in_i),
  .pad_out_o (pad_out_o),
  .pad_oe_o  (pad_oe_o),
  .irq_o     (irq_o),
  .sync_w    (sync_w),
  .latch_w   (latch_w),
  .ien_w     (ien_w),
  .iclr_w    (iclr_w)
);

// File: tb/test_gpio_apb_irq.sv
module test_gpio_apb_irq;
  localparam int CLK_PERIOD = 10;
  localparam int N = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [5:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready;
  logic [N-1:0] pad_in = '0;
  logic [N-1:0] pad_out, pad_oe;
  logic        irq;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [N-1:0] m_oe = '0, m_out = '0, m_en = '0, m_typ = '0, m_pol = '0, m_both = '0;
  logic [N-1:0] m_latch = '0, m_pad = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_apb_irq i_gpio_apb_irq (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .psel_i    (psel),
    .penable_i (penable),
    .pwrite_i  (pwrite),
    .paddr_i   (paddr),
    .pwdata_i  (pwdata),
    .prdata_o  (prdata),
    .pready_o  (pready),
    .pad_in_i  (pad_in),
    .pad_out_o (pad_out),
    .pad_oe_o  (pad_oe),
    .irq_o     (irq)
  );

  function automatic logic [N-1:0] exp_pend();
    return m_en & ((m_typ & m_latch) |
                   (~m_typ & ((m_pol & m_pad) | (~m_pol & ~m_pad))));
  endfunction

  function automatic logic [N-1:0] edge_hits(logic [N-1:0] o, logic [N-1:0] n);
    logic [N-1:0] r = ~o & n;
    logic [N-1:0] f = o & ~n;
    return m_en & m_typ & ((m_both & (r | f)) | (~m_both & m_pol & r) | (~m_both & ~m_pol & f));
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_test();
    if (!done) begin
      done = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  // called at a falling edge; returns at a falling edge
  task automatic apb_write(logic [5:0] a, logic [31:0] d);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(posedge clk); @(negedge clk);
    penable = 1'b1;
    @(posedge clk); @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    case (a[5:2])
      4'h0: m_oe   = m_oe & ~d;
      4'h1: m_oe   = m_oe | d;
      4'h2: m_out  = m_out | d;
      4'h3: m_out  = m_out & ~d;
      4'h4: m_en   = d;
      4'h5: m_typ  = d;
      4'h6: m_pol  = d;
      4'h7: m_both = d;
      4'h8: m_latch = m_latch & ~d;
      default: ;
    endcase
  endtask

  task automatic apb_read(logic [5:0] a, output logic [31:0] d);
    psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(posedge clk); @(negedge clk);
    penable = 1'b1;
    #1 d = prdata;
    @(posedge clk); @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic drive_pad(logic [N-1:0] v);
    m_latch = m_latch | edge_hits(m_pad, v);
    m_pad = v;
    pad_in = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic check_outputs(string req);
    logic [31:0] rd;
    check({req, " pad_out"}, pad_out, m_out);
    check({req, " pad_oe"}, pad_oe, m_oe);
    apb_read(6'h0C, rd);
    check("R4/R6/R7/R8 pending word", rd, exp_pend());
    check("R9 irq", {31'd0, irq}, {31'd0, |exp_pend()});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_test();
  end

  initial begin
    logic [31:0] rd;
    int unused_seed;
    unused_seed = $urandom(32'h5eed_0042);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 oe", pad_oe, '0);
    check("R1 out", pad_out, '0);
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R11 pready", {31'd0, pready}, 32'd1);
    apb_read(6'h10, rd); check("R1 enable word", rd, '0);
    apb_read(6'h0C, rd); check("R1 pending word", rd, '0);

    // R2 direction masks
    apb_write(6'h04, 32'h0000_ff0f);
    check("R2 make output", pad_oe, 32'h0000_ff0f);
    apb_write(6'h00, 32'h0000_0f01);
    check("R2 make input", pad_oe, 32'h0000_f00e);
    apb_read(6'h00, rd); check("R2 readback 0x00", rd, 32'h0000_f00e);
    apb_read(6'h04, rd); check("R2 readback 0x04", rd, 32'h0000_f00e);

    // R3 / R4 set and clear
    apb_write(6'h08, 32'hf0f0_0003);
    check("R3 set", pad_out, 32'hf0f0_0003);
    apb_write(6'h0C, 32'h30f0_0001);
    check("R4 clear", pad_out, 32'hc000_0002);

    // R11 config readback, clear word reads 0
    apb_write(6'h14, 32'h1234_5678); apb_read(6'h14, rd); check("R11 type rb", rd, 32'h1234_5678);
    apb_write(6'h18, 32'h9abc_def0); apb_read(6'h18, rd); check("R11 pol rb", rd, 32'h9abc_def0);
    apb_write(6'h1C, 32'h0f0f_0f0f); apb_read(6'h1C, rd); check("R11 both rb", rd, 32'h0f0f_0f0f);
    apb_read(6'h20, rd); check("R11 clear reads 0", rd, '0);
    apb_write(6'h14, 0); apb_write(6'h18, 0); apb_write(6'h1C, 0);

    // R5 two-flop delay: a read one edge after the change sees the old state
    pad_in = 32'h0000_00a5; m_pad = 32'h0000_00a5;
    apb_read(6'h08, rd); check("R5 state not yet", rd, 32'h0);
    apb_read(6'h08, rd); check("R5 state after sync", rd, 32'h0000_00a5);
    drive_pad('0);

    // R6 level active high / low on pins 1 and 2
    apb_write(6'h18, 32'h2);
    apb_write(6'h10, 32'h6);
    apb_read(6'h0C, rd); check("R6 active low pending", rd, 32'h4);
    drive_pad(32'h6);
    apb_read(6'h0C, rd); check("R6 active high pending", rd, 32'h2);
    drive_pad(32'h0);
    apb_read(6'h0C, rd); check("R6 condition gone", rd, 32'h4);
    apb_write(6'h10, 0);

    // R8 disabled edge pin latches nothing
    apb_write(6'h14, 32'h1); apb_write(6'h18, 32'h1);
    drive_pad(32'h1);
    apb_write(6'h10, 32'h1);
    apb_read(6'h0C, rd); check("R8 no latch while disabled", rd, 32'h0);
    check("R8 irq low", {31'd0, irq}, 32'd0);

    // R7 rising edge latched, survives pad return, cleared by write
    drive_pad(32'h0);
    drive_pad(32'h1);
    drive_pad(32'h0);
    apb_read(6'h0C, rd); check("R7 latched rising", rd, 32'h1);
    check("R9 irq high", {31'd0, irq}, 32'd1);
    apb_write(6'h20, 32'h1);
    apb_read(6'h0C, rd); check("R7 cleared", rd, 32'h0);

    // R10 edge arriving in the clear cycle keeps it pending
    drive_pad(32'h1);
    drive_pad(32'h0);
    pad_in = 32'h1;           // rising edge lands on the third edge
    m_pad = 32'h1;
    @(posedge clk); @(negedge clk);
    apb_write(6'h20, 32'h1);  // write lands on the same edge
    m_latch = 32'h1;
    apb_read(6'h0C, rd); check("R10 edge wins over clear", rd, 32'h1);
    apb_write(6'h20, 32'h1);
    apb_read(6'h0C, rd); check("R10 plain clear", rd, 32'h0);

    // R7 both edges
    apb_write(6'h1C, 32'h1);
    drive_pad(32'h0);
    apb_read(6'h0C, rd); check("R7 both-edge falling", rd, 32'h1);
    apb_write(6'h20, 32'h1);
    apb_write(6'h1C, 32'h0); apb_write(6'h18, 32'h0);
    drive_pad(32'h1);
    apb_read(6'h0C, rd); check("R7 falling mode ignores rise", rd, 32'h0);
    drive_pad(32'h0);
    apb_read(6'h0C, rd); check("R7 falling mode latches fall", rd, 32'h1);

    // random mix
    for (int i = 0; i < 300; i++) begin
      int op = $urandom % 12;
      logic [31:0] d = $urandom;
      case (op)
        0: apb_write(6'h00, d);
        1: apb_write(6'h04, d);
        2: apb_write(6'h08, d);
        3: apb_write(6'h0C, d);
        4: apb_write(6'h10, d);
        5: apb_write(6'h14, d);
        6: apb_write(6'h18, d);
        7: apb_write(6'h1C, d);
        8: apb_write(6'h20, d);
        default: drive_pad(m_pad ^ (d & $urandom));
      endcase
      check_outputs("R2/R3/R4 random");
      if (i % 10 == 0) begin
        apb_read(6'h08, rd); check("R3 state random", rd, m_pad);
      end
    end

    finish_test();
  end
endmodule